// File: doc/BRIEF.md
# Receive Byte Queue with Threshold and Idle Flags

This block buffers received serial bytes for a host and raises two status flags. A deserializer outside the block delivers each byte with a one-cycle valid strobe and, separately, a pulse marking the end of the stop bit. An external source supplies one tick per elementary time unit (etu). The host takes bytes from a read port that always shows the oldest stored byte, and it can see how many bytes are stored at any time.

The threshold flag tells the host that enough bytes are waiting to justify a burst read. The host picks that level with a two-bit select. The idle flag tells the host that a partial burst has stalled: fewer bytes than the threshold are stored and the line has been quiet for 15 etu after the last stop bit. That is about one and a half frames of 8 data bits and 1 stop bit. The host clears either flag by reading it as one and then writing zero to it. The threshold flag clears only if the fill has dropped below the threshold by the time of the write. A standby input forces both flags low without touching the stored bytes.

Top module: `rx_fifo_flags`

## Requirements
- R1: The queue holds up to 16 bytes. `fill_o` reports the stored count, from 0 to 16, and is updated at the clock edge that samples a push (`rx_valid_i`) or a pop (`pop_i`). A push and a pop in the same cycle leave the count unchanged.
- R2: `pop_data_o` shows the oldest stored byte, and shows 0 when the queue is empty. A pop while the queue is empty changes nothing.
- R3: A push while `fill_o` is 16 is dropped, even if a pop happens in the same cycle. `overrun_o` is then high for exactly the following cycle.
- R4: `trig_sel_i` sets the threshold: code 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14.
- R5: `full_flag_o` goes high at the edge where an accepted push leaves the fill at or above the threshold.
- R6: `full_flag_o` clears on a write whose bit 1 is 0. The write must follow a cycle with `flag_rd_i` high while the flag was 1, and the fill must be below the threshold in the cycle of the write. Any write with bit 1 at 0 uses up that read, whether or not the flag clears.
- R7: The idle timer restarts on `stop_end_i` and advances on `etu_tick_i` only while the queue is non-empty. On the 15th such tick it fires once and then stays idle until the next `stop_end_i`. If the fill is below the threshold when it fires, `ready_flag_o` goes high at the next edge.
- R8: `ready_flag_o` clears on a write whose bit 0 is 0, provided the write follows a read (`flag_rd_i`) that saw the flag at 1.
- R9: A write of 0 to a flag that was not first read as 1 leaves the flag unchanged. A write of 1 never changes a flag.
- R10: `standby_i` clears both flags and any pending read, and stops the idle timer. It leaves the stored bytes and `fill_o` unchanged.
- R11: If a set condition and a valid clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Clears both flags and stops the idle timer |
| rx_valid_i | input | 1 | Received byte strobe (push) |
| rx_data_i | input | 8 | Received byte |
| stop_end_i | input | 1 | End-of-stop-bit pulse |
| etu_tick_i | input | 1 | One pulse per etu |
| pop_i | input | 1 | Host pop strobe |
| pop_data_o | output | 8 | Oldest stored byte, 0 when empty |
| fill_o | output | 5 | Stored byte count |
| trig_sel_i | input | 2 | Threshold select |
| flag_rd_i | input | 1 | Host read strobe of the flag register |
| flag_wr_i | input | 1 | Host write strobe of the flag register |
| flag_wdata_i | input | 2 | Write data: bit 1 threshold flag, bit 0 idle flag |
| full_flag_o | output | 1 | Threshold flag |
| ready_flag_o | output | 1 | Idle timeout flag |
| overrun_o | output | 1 | One-cycle pulse after a dropped push |

## Verification
Each threshold code is tried by filling the queue from empty. This shows whether the flag rises exactly on the byte that reaches the selected level and not one byte early or late. The clear handshake is tried in three forms: a write without a prior read, a read followed by a write while the fill is still at the threshold, and a read followed by a write after pops have taken the fill below it. These separate the arming rule from the fill-level condition. Timer patterns count exactly 15 ticks, then add extra ticks, then send ticks while the queue is empty. They show whether the timer fires once, stays silent after firing, and pauses on an empty queue. A long random phase overfills the queue and mixes pushes and pops in the same cycle, standby and handshake traffic. It is compared on every cycle against a queue-based model.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned TRIG_SEL_W = 2;

  function automatic int unsigned trig_level(input logic [TRIG_SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_nxt_o,
  output logic              push_ok_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              overrun_q;
  logic              pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok_o   = push_i && (count_q != CNT_W'(DEPTH));
  assign pop_ok      = pop_i && (count_q != '0);
  assign count_nxt_o = count_q + CNT_W'(push_ok_o) - CNT_W'(pop_ok);
  assign head_o      = (count_q == '0) ? '0 : mem_q[rd_ptr_q];
  assign count_o     = count_q;
  assign overrun_o   = overrun_q;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)    rd_ptr_q <= ptr_inc(rd_ptr_q);
      count_q   <= count_nxt_o;
      overrun_q <= push_i && !push_ok_o;
    end
  end

  // R1
  fill_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R2
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_q == '0 && !push_i) |=> (count_q == '0 && $stable(rd_ptr_q)));
  // R3
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_q |-> ($past(push_i) && $past(count_q) == CNT_W'(DEPTH)));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int unsigned LIMIT = 15,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic restart_i,
  input  logic tick_i,
  input  logic enable_i,
  output logic fire_o
);
  logic [CW-1:0] cnt_q;
  logic          running_q;
  logic          adv;

  assign adv    = !clear_i && !restart_i && running_q && tick_i && enable_i;
  assign fire_o = adv && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q     <= '0;
      running_q <= 1'b1;
    end else if (fire_o) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (adv) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !clear_i) |=> (running_q && cnt_q == '0));
  // R7
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !restart_i) |=> !fire_o);
  // R10
  standby_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !running_q);
endmodule

// File: rtl/rx_flag_cell.sv
module rx_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  input  logic clr_ok_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q, wr_zero;

  assign wr_zero = wr_i && !wbit_i;
  assign flag_o  = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (clear_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                            flag_q <= 1'b1;
      else if (wr_zero && arm_q && clr_ok_i) flag_q <= 1'b0;
      if (rd_i && flag_q) arm_q <= 1'b1;
      else if (wr_zero)   arm_q <= 1'b0;
    end
  end

  // R9
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(clear_i) ||
      ($past(wr_zero) && $past(arm_q) && $past(clr_ok_i))));
  // R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clear_i) |=> flag_q);
  // R10
  standby_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!flag_q && !arm_q));
endmodule

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TIMEOUT_ETU = 15,
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  standby_i,
  input  logic                  rx_valid_i,
  input  logic [DATA_W-1:0]     rx_data_i,
  input  logic                  stop_end_i,
  input  logic                  etu_tick_i,
  input  logic                  pop_i,
  output logic [DATA_W-1:0]     pop_data_o,
  output logic [CNT_W-1:0]      fill_o,
  input  logic [TRIG_SEL_W-1:0] trig_sel_i,
  input  logic                  flag_rd_i,
  input  logic                  flag_wr_i,
  input  logic [1:0]            flag_wdata_i,
  output logic                  full_flag_o,
  output logic                  ready_flag_o,
  output logic                  overrun_o
);
  logic [CNT_W-1:0] count, count_nxt, trig_lvl;
  logic             push_ok, fire, below_trig;

  assign trig_lvl   = CNT_W'(trig_level(trig_sel_i));
  assign below_trig = count < trig_lvl;
  assign fill_o     = count;

  rx_byte_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .data_i(rx_data_i), .pop_i,
    .head_o(pop_data_o), .count_o(count), .count_nxt_o(count_nxt),
    .push_ok_o(push_ok), .overrun_o
  );

  rx_idle_timer #(.LIMIT(TIMEOUT_ETU)) u_timer (
    .clk_i, .rst_ni,
    .clear_i(standby_i), .restart_i(stop_end_i), .tick_i(etu_tick_i),
    .enable_i(count != '0), .fire_o(fire)
  );

  rx_flag_cell u_full (
    .clk_i, .rst_ni, .clear_i(standby_i),
    .set_i(push_ok && count_nxt >= trig_lvl), .clr_ok_i(below_trig),
    .rd_i(flag_rd_i), .wr_i(flag_wr_i), .wbit_i(flag_wdata_i[1]),
    .flag_o(full_flag_o)
  );

  rx_flag_cell u_ready (
    .clk_i, .rst_ni, .clear_i(standby_i),
    .set_i(fire && below_trig), .clr_ok_i(1'b1),
    .rd_i(flag_rd_i), .wr_i(flag_wr_i), .wbit_i(flag_wdata_i[0]),
    .flag_o(ready_flag_o)
  );

  // R5
  full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_flag_o) |-> ($past(rx_valid_i) && fill_o >= $past(trig_lvl)));
  // R6
  full_clear_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_flag_o) |-> ($past(standby_i) || $past(fill_o) < $past(trig_lvl)));
endmodule

// File: tb/rx_fifo_flags_tb.sv
module rx_fifo_flags_tb_top;
  localparam int DEPTH = 16;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni = 1'b0, standby = 0, rx_valid = 0, stop_end = 0, tick = 0, pop = 0;
  logic       flag_rd = 0, flag_wr = 0, full_f, ready_f, ovr;
  logic [7:0] rx_data = 0, pop_data;
  logic [4:0] fill;
  logic [1:0] trig_sel = 0, wdata = 0;

  rx_fifo_flags dut_i (
    .clk_i(clk), .rst_ni, .standby_i(standby), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .stop_end_i(stop_end), .etu_tick_i(tick), .pop_i(pop), .pop_data_o(pop_data),
    .fill_o(fill), .trig_sel_i(trig_sel), .flag_rd_i(flag_rd), .flag_wr_i(flag_wr),
    .flag_wdata_i(wdata), .full_flag_o(full_f), .ready_flag_o(ready_f), .overrun_o(ovr)
  );

  int checks = 0, fails = 0;
  byte unsigned q[$];
  bit m_full, m_ready, m_farm, m_rarm, m_ovr, m_run;
  int m_cnt;

  function automatic int tl(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int  old  = q.size();
    int  trig = tl(trig_sel);
    bit  pop_ok = pop && old > 0;
    bit  push_ok = rx_valid && old < DEPTH;
    bit  fire = 0;
    bit  of = m_full, orf = m_ready;
    m_ovr = rx_valid && old == DEPTH;
    if (standby) begin m_run = 0; m_cnt = 0; end
    else if (stop_end) begin m_run = 1; m_cnt = 0; end
    else if (tick && m_run && old > 0) begin
      if (m_cnt == 14) begin fire = 1; m_run = 0; m_cnt = 0; end
      else m_cnt++;
    end
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(rx_data);
    if (standby) begin
      m_full = 0; m_ready = 0; m_farm = 0; m_rarm = 0;
    end else begin
      if (push_ok && q.size() >= trig) m_full = 1;
      else if (flag_wr && !wdata[1] && m_farm && old < trig) m_full = 0;
      if (fire && old < trig) m_ready = 1;
      else if (flag_wr && !wdata[0] && m_rarm) m_ready = 0;
      if (flag_rd && of) m_farm = 1; else if (flag_wr && !wdata[1]) m_farm = 0;
      if (flag_rd && orf) m_rarm = 1; else if (flag_wr && !wdata[0]) m_rarm = 0;
    end
  endtask

  task automatic compare();
    int exp_d = q.size() > 0 ? q[0] : 0;
    chk(fill == q.size(), "R1 fill", fill, q.size());
    chk(pop_data == exp_d, "R2 pop_data", pop_data, exp_d);
    chk(ovr == m_ovr, "R3 overrun", ovr, m_ovr);
    chk(full_f == m_full, "R5/R6 full_flag", full_f, m_full);
    chk(ready_f == m_ready, "R7/R8 ready_flag", ready_f, m_ready);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    standby = 0; rx_valid = 0; stop_end = 0; tick = 0; pop = 0; flag_rd = 0; flag_wr = 0;
  endtask

  task automatic push_byte(input byte unsigned d);
    rx_valid = 1; rx_data = d; cyc();
    stop_end = 1; cyc();
  endtask

  task automatic drain();
    while (q.size() > 0) begin pop = 1; cyc(); end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fill == 0 && full_f == 0 && ready_f == 0 && ovr == 0, "R1 reset state", fill, 0);
    rst_ni = 1;
    cyc();
    // R4: threshold per select code
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s); standby = 1; cyc();
      chk(full_f == 0, "R10 standby clears", full_f, 0);
      for (int i = 0; i < tl(2'(s)); i++) begin
        chk(full_f == 0, "R4 no early flag", full_f, 0);
        push_byte(byte'(8'h10 * s + i));
      end
      chk(full_f == 1 && fill == tl(2'(s)), "R4 flag at level", fill, tl(2'(s)));
      drain();
    end
    // R9/R6 handshake on full flag, trig 4
    trig_sel = 1; standby = 1; cyc();
    for (int i = 0; i < 5; i++) push_byte(byte'(i + 8'h40));
    flag_wr = 1; wdata = 2'b00; cyc();
    chk(full_f == 1, "R9 write without read", full_f, 1);
    flag_rd = 1; cyc();
    flag_wr = 1; wdata = 2'b11; cyc();
    chk(full_f == 1, "R9 write one ignored", full_f, 1);
    flag_wr = 1; wdata = 2'b00; cyc();
    chk(full_f == 1, "R6 fill still at level", full_f, 1);
    flag_rd = 1; cyc();
    pop = 1; cyc(); pop = 1; cyc();
    flag_wr = 1; wdata = 2'b00; cyc();
    chk(full_f == 0, "R6 cleared below level", full_f, 0);
    drain();
    // R7/R8 timeout, trig 8
    trig_sel = 2; standby = 1; cyc();
    push_byte(8'hA5); push_byte(8'h5A);
    for (int i = 0; i < 14; i++) begin tick = 1; cyc(); end
    chk(ready_f == 0, "R7 not before 15", ready_f, 0);
    tick = 1; cyc();
    chk(ready_f == 1, "R7 fires at 15", ready_f, 1);
    flag_rd = 1; cyc();
    flag_wr = 1; wdata = 2'b10; cyc();
    chk(ready_f == 0, "R8 cleared", ready_f, 0);
    for (int i = 0; i < 20; i++) begin tick = 1; cyc(); end
    chk(ready_f == 0, "R7 no retrigger", ready_f, 0);
    drain();
    stop_end = 1; cyc();
    for (int i = 0; i < 20; i++) begin tick = 1; cyc(); end
    chk(ready_f == 0, "R7 paused when empty", ready_f, 0);
    // R3 overrun
    for (int i = 0; i < 17; i++) begin rx_valid = 1; rx_data = byte'(i); cyc(); end
    chk(fill == 16, "R3 held at 16", fill, 16);
    rx_valid = 1; pop = 1; cyc();
    chk(fill == 15, "R3 drop with pop", fill, 15);
    // R10 standby keeps bytes
    standby = 1; cyc();
    chk(fill == 15, "R10 bytes kept", fill, 15);
    drain();
    // random phase
    for (int n = 0; n < 20000; n++) begin
      rx_valid = ($urandom_range(0, 2) == 0); rx_data = 8'($urandom);
      pop = ($urandom_range(0, 3) == 0);
      stop_end = ($urandom_range(0, 20) == 0);
      tick = ($urandom_range(0, 1) == 0);
      flag_rd = ($urandom_range(0, 5) == 0);
      flag_wr = ($urandom_range(0, 5) == 0); wdata = 2'($urandom);
      standby = ($urandom_range(0, 300) == 0);
      if ($urandom_range(0, 500) == 0) trig_sel = 2'($urandom);
      cyc();
    end
    summary();
  end
endmodule